// File: doc/BRIEF.md
# Decorated Store AND Read-Modify-Write Engine

This block sits between a bus master and a peripheral memory region. Most accesses go straight through it. A write can also carry an operation code in otherwise unused upper address bits. When that code selects a logical AND on peripheral space, the engine does not forward the store. It reads the target location, ANDs the value it reads with the store's data, and writes the result back to the same place. The master sees this as one atomic store that takes longer than usual.

The master side is a simple request/response port. A request is presented with its address, size, direction and write data, and it is taken in any cycle where `reqAccept` is high. Completion is signalled by a one-cycle `respDone` pulse. The memory side issues one command per cycle, with address, size, byte strobes and write data. Read data returns on the cycle after a read command. Byte and halfword store data is supplied in the low bits of the write data and is copied across every byte lane of the 32-bit bus.

Top module: `decor_and_rmw`

## Requirements
- R1: A request is decorated only if it is a write, address bits [30:29] equal 2'b10 and bits [28:26] equal 3'b001. Every other request, including a read at such an address and a write with [28:26] = 3'b010 or [30:29] = 2'b01, is forwarded with its address unchanged.
- R2: In the cycle a decorated store is accepted, the memory side issues a read (`memValid`=1, `memWrite`=0) at the request address ANDed with 0xE00FFFFF.
- R3: In the next cycle, the memory side issues a write to the same address. In the selected byte lanes the data is the read word ANDed with the replicated store data. In the other lanes the data equals the read word.
- R4: Byte strobes follow the size code `memSize` = `reqSize`. Size 0 (byte) gives 1 << addr[1:0]. Size 1 (halfword) gives 2'b11 << (2*addr[1]). Size 2 (word) gives 4'hF.
- R5: Write data is replicated across lanes. A byte copies wdata[7:0] into all four lanes, a halfword copies wdata[15:0] into both halves, and a word is passed as is.
- R6: A forwarded access is issued to memory in the cycle it is accepted, with `memWrite` = `reqWrite`. `respDone` pulses one cycle later with `busy` low, and for a read `respRdata` then holds the memory word.
- R7: After a decorated store is accepted, `busy` is high for two cycles and `respDone` pulses only in the second of them.
- R8: No request is accepted while a transfer is in progress. `reqAccept` is low, and a request held during a read-modify-write produces no memory command and does not change the write-back address.
- R9: While `rstN` is low, `memValid`, `busy` and `respDone` are low and the engine is idle, with `reqAccept` high once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Master request present |
| reqWrite | input | 1 | Request is a store |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqAddr | input | 32 | Request address, including decoration bits |
| reqWdata | input | 32 | Store data, low-aligned for narrow sizes |
| reqAccept | output | 1 | Engine idle, request taken this cycle |
| respDone | output | 1 | Access completed |
| respRdata | output | 32 | Read data for a completed read |
| busy | output | 1 | Read-modify-write in progress |
| memValid | output | 1 | Memory command valid |
| memWrite | output | 1 | Memory command is a write |
| memAddr | output | 32 | Memory address |
| memSize | output | 2 | Memory access size |
| memStrb | output | 4 | Byte lane enables |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, one cycle after a read |

## Verification
Assertions check every cycle that:
- an accepted decorated store is followed by a write-back while busy;
- the write-back reuses the address of the read;
- the write-back never sets a bit that was clear in the word read;
- strobe counts match the size;
- reset keeps the memory side quiet.

The lane-exact result of each AND, the replication of narrow data and the unchanged forwarding of near-miss decorations can only be shown by the bench. It sweeps every size and lane offset against a shadow memory and reads each word back afterwards.

// File: rtl/decor_pkg.sv
package decor_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_WB   = 2'd2,
    ST_DONE = 2'd3
  } rmwState_t;

  typedef struct packed {
    logic capture;
    logic useMask;
    logic issueWb;
  } ctrlStrb_t;
endpackage

// File: rtl/decor_ctrl.sv
module decor_ctrl
  import decor_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      addrDecorated,
  output ctrlStrb_t strb,
  output logic      memValid,
  output logic      memWrite,
  output logic      reqAccept,
  output logic      busy,
  output logic      respDone
);
  rmwState_t state, stateNext;
  logic takeReq, takeRmw;

  assign takeReq = rstN && (state == ST_IDLE) && reqValid;
  assign takeRmw = takeReq && reqWrite && addrDecorated;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (takeReq) stateNext = takeRmw ? ST_WB : ST_PASS;
      ST_PASS: stateNext = ST_IDLE;
      ST_WB:   stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.capture = takeRmw;
    strb.useMask = takeRmw;
    strb.issueWb = rstN && (state == ST_WB);
  end

  assign memValid  = takeReq || strb.issueWb;
  assign memWrite  = strb.issueWb || (takeReq && reqWrite && !addrDecorated);
  assign reqAccept = (state == ST_IDLE);
  assign busy      = rstN && (state == ST_WB || state == ST_DONE);
  assign respDone  = rstN && (state == ST_PASS || state == ST_DONE);

  // R7
  decorated_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAccept && reqWrite && addrDecorated) |=> (busy && memValid && memWrite && !respDone));

  // R7
  wb_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memValid) |=> (busy && respDone && !memValid));

  // R6
  pass_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAccept && !(reqWrite && addrDecorated)) |=> (respDone && !busy && !memValid));

  // R8
  accept_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAccept) |=> !reqAccept);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!memValid && !busy && !respDone));
endmodule

// File: rtl/decor_datapath.sv
module decor_datapath
  import decor_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SIZE_W      = 2,
  parameter int OFFSET_W    = 20,
  parameter int REGION_LO   = 29,
  parameter int OP_LO       = 26,
  parameter int OP_W        = 3,
  parameter logic [1:0] REGION_CODE = 2'b10,
  parameter logic [2:0] OP_AND_CODE = 3'b001
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              addrDecorated,
  output logic [ADDR_W-1:0] memAddr,
  output logic [SIZE_W-1:0] memSize,
  output logic [DATA_W/8-1:0] memStrb,
  output logic [DATA_W-1:0] memWdata
);
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);
  localparam int GAP_W     = REGION_LO - OFFSET_W;

  logic [ADDR_W-1:0] maskedAddr, capAddr;
  logic [SIZE_W-1:0] capSize;
  logic [LANES-1:0]  reqLanes, capLanes;
  logic [DATA_W-1:0] reqRepl, capRepl, mergedData;

  function automatic logic [LANES-1:0] laneSel(input logic [SIZE_W-1:0] sz,
                                               input logic [LANE_BITS-1:0] low);
    logic [LANES-1:0] sel;
    for (int i = 0; i < LANES; i++)
      sel[i] = ((LANE_BITS'(i) >> sz) == (low >> sz));
    return sel;
  endfunction

  function automatic logic [DATA_W-1:0] replicate(input logic [DATA_W-1:0] d,
                                                  input logic [SIZE_W-1:0] sz);
    logic [DATA_W-1:0]    r;
    logic [LANE_BITS-1:0] szMask;
    logic [LANE_BITS-1:0] src;
    szMask = LANE_BITS'((1 << sz) - 1);
    for (int i = 0; i < LANES; i++) begin
      src = LANE_BITS'(i) & szMask;
      r[8*i +: 8] = d[8*src +: 8];
    end
    return r;
  endfunction

  assign addrDecorated = (reqAddr[REGION_LO +: 2] == REGION_CODE) &&
                         (reqAddr[OP_LO +: OP_W] == OP_AND_CODE);
  assign maskedAddr = {reqAddr[ADDR_W-1:REGION_LO], {GAP_W{1'b0}}, reqAddr[OFFSET_W-1:0]};
  assign reqLanes   = laneSel(reqSize, reqAddr[LANE_BITS-1:0]);
  assign reqRepl    = replicate(reqWdata, reqSize);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr  <= '0;
      capSize  <= '0;
      capLanes <= '0;
      capRepl  <= '0;
    end else if (strb.capture) begin
      capAddr  <= maskedAddr;
      capSize  <= reqSize;
      capLanes <= reqLanes;
      capRepl  <= reqRepl;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mergedData[8*g +: 8] = capLanes[g] ? (memRdata[8*g +: 8] & capRepl[8*g +: 8])
                                              : memRdata[8*g +: 8];
  end

  always_comb begin
    if (strb.issueWb) begin
      memAddr  = capAddr;
      memSize  = capSize;
      memStrb  = capLanes;
      memWdata = mergedData;
    end else begin
      memAddr  = strb.useMask ? maskedAddr : reqAddr;
      memSize  = reqSize;
      memStrb  = reqLanes;
      memWdata = reqRepl;
    end
  end

  // R3
  wb_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueWb |-> (memAddr == $past(memAddr)));

  // R3
  wb_clears_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueWb |-> ((memWdata & ~memRdata) == '0));

  // R4
  strobe_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(memSize) <= LANE_BITS) |-> ($countones(memStrb) == (1 << memSize)));

  // R2
  masked_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (memAddr[REGION_LO-1:OFFSET_W] == '0));
endmodule

// File: rtl/decor_and_rmw.sv
module decor_and_rmw
  import decor_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SIZE_W   = 2,
  parameter int OFFSET_W = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [SIZE_W-1:0]   reqSize,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                reqAccept,
  output logic                respDone,
  output logic [DATA_W-1:0]   respRdata,
  output logic                busy,
  output logic                memValid,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [SIZE_W-1:0]   memSize,
  output logic [DATA_W/8-1:0] memStrb,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata
);
  ctrlStrb_t strb;
  logic      addrDecorated;

  decor_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .addrDecorated(addrDecorated), .strb(strb), .memValid(memValid),
    .memWrite(memWrite), .reqAccept(reqAccept), .busy(busy), .respDone(respDone)
  );

  decor_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .OFFSET_W(OFFSET_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWdata(reqWdata), .memRdata(memRdata), .addrDecorated(addrDecorated),
    .memAddr(memAddr), .memSize(memSize), .memStrb(memStrb), .memWdata(memWdata)
  );

  assign respRdata = memRdata;
endmodule

// File: tb/decor_and_rmw_bench.sv
`timescale 1ns/1ps
module decor_and_rmw_bench;
  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0, reqWrite = 0;
  logic [1:0]  reqSize = 0;
  logic [31:0] reqAddr = 0, reqWdata = 0;
  logic        reqAccept, respDone, busy, memValid, memWrite;
  logic [31:0] respRdata, memAddr, memWdata;
  logic [1:0]  memSize;
  logic [3:0]  memStrb;
  logic [31:0] memRdata = 0;
  logic [31:0] ram [16];
  logic [31:0] shadow [16];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  decor_and_rmw u_decor_and_rmw (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqAccept(reqAccept), .respDone(respDone), .respRdata(respRdata), .busy(busy),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr), .memSize(memSize),
    .memStrb(memStrb), .memWdata(memWdata), .memRdata(memRdata)
  );

  always_ff @(posedge clk) begin
    if (memValid && memWrite) begin
      for (int b = 0; b < 4; b++)
        if (memStrb[b]) ram[memAddr[5:2]][8*b +: 8] <= memWdata[8*b +: 8];
    end else if (memValid) begin
      memRdata <= ram[memAddr[5:2]];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expStrb(input logic [1:0] sz, input logic [31:0] ad);
    case (sz)
      2'd0:    return 4'b0001 << ad[1:0];
      2'd1:    return 4'b0011 << {ad[1], 1'b0};
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [31:0] expRepl(input logic [1:0] sz, input logic [31:0] wd);
    case (sz)
      2'd0:    return {4{wd[7:0]}};
      2'd1:    return {2{wd[15:0]}};
      default: return wd;
    endcase
  endfunction

  function automatic logic [31:0] laneMask(input logic [3:0] s);
    return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
  endfunction

  task automatic runAccess(input logic wr, input logic [1:0] sz, input logic [31:0] ad,
                           input logic [31:0] wd, input bit poke);
    logic        dec;
    logic [31:0] ea, merged, repl;
    logic [3:0]  st;
    int          idx;
    dec  = wr && (ad[30:29] == 2'b10) && (ad[28:26] == 3'b001);
    ea   = dec ? (ad & 32'hE00F_FFFF) : ad;
    idx  = int'(ea[5:2]);
    st   = expStrb(sz, ad);
    repl = expRepl(sz, wd);
    reqValid = 1; reqWrite = wr; reqSize = sz; reqAddr = ad; reqWdata = wd;
    #1;
    chk(reqAccept === 1'b1, "R8 accept when idle", {31'b0, reqAccept}, 32'd1);
    chk(memValid === 1'b1 && memWrite === (wr && !dec), dec ? "R2 read issued" : "R6 forward cmd",
        {30'b0, memValid, memWrite}, {30'b0, 1'b1, wr && !dec});
    chk(memAddr === ea, dec ? "R2 masked address" : "R1 address unchanged", memAddr, ea);
    chk(memStrb === st && memSize === sz, "R4 strobes", {26'b0, memSize, memStrb}, {26'b0, sz, st});
    if (wr && !dec) chk(memWdata === repl, "R5 replication", memWdata, repl);
    @(negedge clk);
    if (dec) begin
      if (poke) begin reqAddr = 32'h4000_003C; reqWrite = 0; end
      else reqValid = 0;
      #1;
      merged = shadow[idx] & (repl | ~laneMask(st));
      chk(busy === 1'b1 && respDone === 1'b0 && reqAccept === 1'b0, "R7 busy first cycle",
          {29'b0, busy, respDone, reqAccept}, 32'd4);
      chk(memValid === 1'b1 && memWrite === 1'b1, "R3 write-back cmd", {30'b0, memValid, memWrite}, 32'd3);
      chk(memAddr === ea, "R3 write-back address", memAddr, ea);
      chk(memStrb === st, "R4 write-back strobes", {28'b0, memStrb}, {28'b0, st});
      chk(memWdata === merged, "R3 merged data", memWdata, merged);
      shadow[idx] = merged;
      @(negedge clk); #1;
      chk(respDone === 1'b1 && busy === 1'b1, "R7 done second cycle", {30'b0, respDone, busy}, 32'd3);
      chk(memValid === 1'b0 && reqAccept === 1'b0, "R8 held request ignored",
          {30'b0, memValid, reqAccept}, 32'd0);
      reqValid = 0;
      @(negedge clk);
    end else begin
      reqValid = 0;
      #1;
      chk(respDone === 1'b1 && busy === 1'b0, "R6 single completion", {30'b0, respDone, busy}, 32'd2);
      if (!wr) chk(respRdata === shadow[idx], "R6 read data", respRdata, shadow[idx]);
      else for (int b = 0; b < 4; b++) if (st[b]) shadow[idx][8*b +: 8] = repl[8*b +: 8];
      @(negedge clk);
    end
  endtask

  task automatic readBack(input int w, input string req);
    logic [31:0] a;
    a = 32'h4000_0000 | (w << 2);
    reqValid = 1; reqWrite = 0; reqSize = 2; reqAddr = a;
    @(negedge clk);
    reqValid = 0; #1;
    chk(respRdata === shadow[w], req, respRdata, shadow[w]);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pats [3];
    int w;
    pats[0] = 32'h5A3C_F00F; pats[1] = 32'h0000_0000; pats[2] = 32'hFFFF_FFFF;
    for (int i = 0; i < 16; i++) begin
      ram[i] = (i * 32'h1111_1111) ^ 32'hF0F0_A5C3;
      shadow[i] = ram[i];
    end
    reqValid = 1; reqWrite = 1; reqAddr = 32'h4400_0000;
    repeat (3) @(negedge clk);
    #1;
    chk(memValid === 1'b0 && busy === 1'b0 && respDone === 1'b0, "R9 quiet in reset",
        {29'b0, memValid, busy, respDone}, 32'd0);
    reqValid = 0;
    rstN = 1;
    @(negedge clk); #1;
    chk(reqAccept === 1'b1 && busy === 1'b0, "R9 idle after reset", {30'b0, reqAccept, busy}, 32'd2);
    @(negedge clk);

    w = 0;
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 4; off += (1 << sz))
        for (int p = 0; p < 3; p++) begin
          logic [31:0] a;
          a = {(p == 1) ? 1'b1 : 1'b0, 2'b10, 3'b001, 6'(p * 21 + off), 12'h000, 6'(w), 2'(off)};
          runAccess(1, 2'(sz), a, pats[p] ^ (32'h0101_0101 * off), (p == 0));
          readBack(w, "R3 stored result");
          w = (w + 5) % 16;
        end

    // R1: near-miss decorations and reads at decorated addresses are forwarded unchanged
    runAccess(1, 2, 32'h4800_0008, 32'h1234_5678, 0);
    readBack(2, "R1 OR code forwarded");
    runAccess(1, 1, 32'h2400_0016, 32'h0000_BEEF, 0);
    readBack(5, "R1 wrong region forwarded");
    runAccess(0, 2, 32'h4450_0020, 32'h0, 0);
    runAccess(1, 0, 32'h4000_0031, 32'h0000_0077, 0);
    readBack(12, "R5 byte write stored");
    runAccess(0, 0, 32'h4000_0013, 32'h0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule